// File: doc/BRIEF.md
# Serial Command Decoder for a Digitally Set Resistor

This block is the serial slave front end of a resistor whose wiper is set by a digital code. A host frames each transfer by pulling a low-active select line down, toggles a serial clock, and presents one data bit per clock. When the select line returns high, the block decides whether the frame is valid. A valid frame has a clock count that is a non-zero multiple of 16 and its two top word bits at zero. The block then acts on a 4-bit command taken from the last 16 bits received. Depending on the command, it updates a 10-bit wiper code, a 4-bit control field or a shutdown flag. It can also raise a one-cycle request to a separate nonvolatile store controller, or arm a readback word. The readback word is shifted out on the serial output during the next frame.

All serial inputs are brought into the system clock domain through a two-stage synchronizer, and their edges are detected there. The serial clock may therefore stop whenever the select line is high. The serial clock idles low. The input bit is captured on each falling serial-clock edge, and the output bit changes on each rising edge.

The controller is a four-state machine. **IDLE** waits for select to fall. It goes to **SHIFT** when the store controller is not busy, and to **LOCKED** when it is. **SHIFT** collects bits. When select rises, it goes to **EXEC** if the frame is valid and the store controller is not busy, and otherwise back to **IDLE**. **LOCKED** ignores all serial activity and returns to **IDLE** when select rises. **EXEC** lasts one cycle: it applies the command and returns to **IDLE**.

Top module: `spi_wiper_decoder`

## Requirements
- R1: A word is shifted in MSB first. Bits 13:10 hold the command and bits 9:0 hold the data. Command 1 loads data bits 9:0 into `wiper_code`.
- R2: Registered outputs change only after select rises. While a frame is being clocked in, `wiper_code`, `ctrl_bits` and `shutdown` hold their previous values.
- R3: A frame is executed only if the number of falling serial-clock edges while select is low is a non-zero multiple of 16. Frames of 0, 15, 17, 31 or 33 clocks change nothing.
- R4: In a valid frame longer than 16 clocks, only the last 16 bits received are decoded.
- R5: A frame whose decoded word has a non-zero value in bits 15:14 changes nothing.
- R6: Command 6 loads data bits 3:0 into `ctrl_bits`.
- R7: Command 8 sets `shutdown` from data bit 0, where 1 means shut down and 0 means normal.
- R8: Commands 2, 7 and 5 arm a 16-bit readback word, which is sent MSB first on `sdo` during the next frame. Each bit is valid from one rising serial-clock edge to the next. Command 2 returns `wiper_code` zero-extended. Command 7 returns `ctrl_bits` zero-extended. Command 5 returns `nv_rdata` as sampled at decode time, and also latches data bits 4:0 into `nv_sel`. In frames longer than 16 clocks, the bits after the first 16 are zero.
- R9: `sdo` is low while select is high. A frame that follows a frame which armed no readback sends only zeros.
- R10: Command 3 raises `store_req` for exactly one cycle, and command 4 raises `restore_req` for exactly one cycle. The two are never high together.
- R11: Commands 0 and 9 to 15 change no output and raise no strobe.
- R12: If `store_busy` is high when select falls, the frame is ignored and `sdo` stays low during it. If `store_busy` is high when select rises, the frame is not executed. In both cases any armed readback is discarded.
- R13: After reset, `wiper_code`, `ctrl_bits`, `shutdown`, `nv_sel`, `sdo` and both strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Frame select, low during a frame |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data in, sampled on the falling serial-clock edge |
| store_busy | input | 1 | High while the store controller is working |
| nv_rdata | input | 16 | Memory or status word returned by command 5 |
| sdo | output | 1 | Serial data out, updated on the rising serial-clock edge |
| wiper_code | output | 10 | Wiper position; zero puts the wiper at terminal B |
| ctrl_bits | output | 4 | Control register |
| shutdown | output | 1 | Shutdown state |
| nv_sel | output | 5 | Memory or status selector latched by command 5 |
| store_req | output | 1 | One-cycle request to store the wiper setting |
| restore_req | output | 1 | One-cycle request to reload the wiper from storage |

## Verification
The assertions assume that the host holds each serial-clock level and each select level for several system clocks. They also assume that select does not rise in the same synchronized cycle as a serial-clock edge, and that select never falls during the single **EXEC** cycle. Under those conditions every edge reaches the state machine alone. The bench drives each serial half period as six system clocks and leaves at least a dozen clocks between frames. It toggles `store_busy` only while select is steady, so random commands, lengths and top bits all stay inside these assumptions.

// File: rtl/wpd_pkg.sv
package wpd_pkg;
    localparam int CMD_W = 4;
    localparam int PAD_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP      = 4'd0,
        CMD_WR_WIPER = 4'd1,
        CMD_RD_WIPER = 4'd2,
        CMD_STORE    = 4'd3,
        CMD_RESTORE  = 4'd4,
        CMD_RD_NV    = 4'd5,
        CMD_WR_CTRL  = 4'd6,
        CMD_RD_CTRL  = 4'd7,
        CMD_SHUTDOWN = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LOCKED,
        ST_EXEC
    } fsm_e;
endpackage

// File: rtl/wpd_sync.sv
module wpd_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [STAGES:0][N-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {(STAGES+1){RST_VAL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], async_in};
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign level[g] = pipe_q[STAGES-1][g];
        assign rise[g]  =  pipe_q[STAGES-1][g] & ~pipe_q[STAGES][g];
        assign fall[g]  = ~pipe_q[STAGES-1][g] &  pipe_q[STAGES][g];
    end
endmodule

// File: rtl/wpd_framer.sv
module wpd_framer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              cnt_clr,
    input  logic              tx_clr,
    input  logic              tx_load,
    input  logic [WORD_W-1:0] tx_value,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_lvl,
    output logic [WORD_W-1:0] word,
    output logic              frame_ok,
    output logic              sdo
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [CNT_W-1:0]  cnt_q;
    logic              full_q;
    logic [WORD_W-1:0] rx_q;
    logic [WORD_W-1:0] tx_q;

    // receive side: falling serial-clock edge captures data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
            rx_q   <= '0;
        end else if (cnt_clr) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else if (shift_en && sclk_fall) begin
            rx_q  <= {rx_q[WORD_W-2:0], din_lvl};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(WORD_W-1)) begin
                full_q <= 1'b1;
            end
        end
    end

    assign word     = rx_q;
    assign frame_ok = full_q && (cnt_q == '0) && (rx_q[WORD_W-1 -: 2] == 2'b00);

    // transmit side: rising serial-clock edge presents the next bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            sdo  <= 1'b0;
        end else if (tx_clr) begin
            tx_q <= '0;
            sdo  <= 1'b0;
        end else if (tx_load) begin
            tx_q <= tx_value;
        end else if (shift_en && sclk_rise) begin
            sdo  <= tx_q[WORD_W-1];
            tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
    end

    assert_sdo_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> !sdo);
    assert_count_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> !frame_ok);
endmodule

// File: rtl/wpd_ctrl.sv
module wpd_ctrl
    import wpd_pkg::*;
#(
    parameter int WIPER_W = 10,
    parameter int CTRL_W  = 4,
    parameter int NVSEL_W = 5,
    parameter int WORD_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sync_fall,
    input  logic                   sync_rise,
    input  logic                   frame_ok,
    input  logic                   store_busy,
    input  logic [WORD_W-3:0]      word,
    input  logic [WORD_W-1:0]      nv_rdata,
    output logic                   shift_en,
    output logic                   cnt_clr,
    output logic                   tx_clr,
    output logic                   tx_load,
    output logic [WORD_W-1:0]      tx_value,
    output logic [WIPER_W-1:0]     wiper_q,
    output logic [CTRL_W-1:0]      ctrl_q,
    output logic                   shutdown_q,
    output logic [NVSEL_W-1:0]     nv_sel_q,
    output logic                   store_req,
    output logic                   restore_req
);
    localparam int CMD_LSB = WIPER_W;

    fsm_e             state_q, state_d;
    logic [CMD_W-1:0] cmd;
    logic [WIPER_W-1:0] data;

    assign cmd  = word[CMD_LSB +: CMD_W];
    assign data = word[WIPER_W-1:0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sync_fall) state_d = store_busy ? ST_LOCKED : ST_SHIFT;
            ST_SHIFT:  if (sync_rise) state_d = (frame_ok && !store_busy) ? ST_EXEC : ST_IDLE;
            ST_LOCKED: if (sync_rise) state_d = ST_IDLE;
            ST_EXEC:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign shift_en = (state_q == ST_SHIFT);
    assign cnt_clr  = (state_q == ST_IDLE) && sync_fall;
    assign tx_clr   = sync_rise && ((state_q == ST_SHIFT) || (state_q == ST_LOCKED));

    // readback selection during EXEC
    always_comb begin
        tx_load  = 1'b0;
        tx_value = '0;
        if (state_q == ST_EXEC) begin
            case (cmd)
                CMD_RD_WIPER: begin
                    tx_load = 1'b1;
                    tx_value[WIPER_W-1:0] = wiper_q;
                end
                CMD_RD_CTRL: begin
                    tx_load = 1'b1;
                    tx_value[CTRL_W-1:0] = ctrl_q;
                end
                CMD_RD_NV: begin
                    tx_load  = 1'b1;
                    tx_value = nv_rdata;
                end
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q     <= '0;
            ctrl_q      <= '0;
            shutdown_q  <= 1'b0;
            nv_sel_q    <= '0;
            store_req   <= 1'b0;
            restore_req <= 1'b0;
        end else begin
            store_req   <= 1'b0;
            restore_req <= 1'b0;
            if (state_q == ST_EXEC) begin
                case (cmd)
                    CMD_WR_WIPER: wiper_q     <= data;
                    CMD_WR_CTRL:  ctrl_q      <= data[CTRL_W-1:0];
                    CMD_SHUTDOWN: shutdown_q  <= data[0];
                    CMD_RD_NV:    nv_sel_q    <= data[NVSEL_W-1:0];
                    CMD_STORE:    store_req   <= 1'b1;
                    CMD_RESTORE:  restore_req <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || restore_req) |=> !(store_req || restore_req));
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && restore_req));
    assert_wiper_after_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_q) |-> $past(state_q == ST_EXEC));
    assert_exec_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC) |-> $past(frame_ok));
    assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sync_rise && store_busy) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/spi_wiper_decoder.sv
module spi_wiper_decoder #(
    parameter int WIPER_W     = 10,
    parameter int CTRL_W      = 4,
    parameter int NVSEL_W     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_n,
    input  logic                 sclk,
    input  logic                 din,
    input  logic                 store_busy,
    input  logic [WIPER_W+5:0]   nv_rdata,
    output logic                 sdo,
    output logic [WIPER_W-1:0]   wiper_code,
    output logic [CTRL_W-1:0]    ctrl_bits,
    output logic                 shutdown,
    output logic [NVSEL_W-1:0]   nv_sel,
    output logic                 store_req,
    output logic                 restore_req
);
    localparam int WORD_W = wpd_pkg::PAD_W + wpd_pkg::CMD_W + WIPER_W;

    logic [2:0] lvl, rse, fll;
    logic              shift_en, cnt_clr, tx_clr, tx_load, frame_ok;
    logic [WORD_W-1:0] tx_value, word;

    wpd_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sync_n, sclk, din}),
        .level    (lvl),
        .rise     (rse),
        .fall     (fll)
    );

    wpd_framer #(.WORD_W(WORD_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .cnt_clr   (cnt_clr),
        .tx_clr    (tx_clr),
        .tx_load   (tx_load),
        .tx_value  (tx_value),
        .sclk_rise (rse[1]),
        .sclk_fall (fll[1]),
        .din_lvl   (lvl[0]),
        .word      (word),
        .frame_ok  (frame_ok),
        .sdo       (sdo)
    );

    // select is low-active: its falling level edge opens a frame
    wpd_ctrl #(.WIPER_W(WIPER_W), .CTRL_W(CTRL_W), .NVSEL_W(NVSEL_W), .WORD_W(WORD_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_fall   (fll[2]),
        .sync_rise   (rse[2]),
        .frame_ok    (frame_ok),
        .store_busy  (store_busy),
        .word        (word[WORD_W-3:0]),
        .nv_rdata    (nv_rdata),
        .shift_en    (shift_en),
        .cnt_clr     (cnt_clr),
        .tx_clr      (tx_clr),
        .tx_load     (tx_load),
        .tx_value    (tx_value),
        .wiper_q     (wiper_code),
        .ctrl_q      (ctrl_bits),
        .shutdown_q  (shutdown),
        .nv_sel_q    (nv_sel),
        .store_req   (store_req),
        .restore_req (restore_req)
    );

    assert_sdo_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[2] && $past(lvl[2]) && $past(lvl[2], 2)) |-> !sdo);
endmodule

// File: tb/sim_spi_wiper_decoder.sv
`timescale 1ns/1ps
module sim_spi_wiper_decoder;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b1, sclk = 1'b0, din = 1'b0, store_busy = 1'b0;
    logic [15:0] nv_rdata = 16'hA5C3;
    logic sdo, shutdown, store_req, restore_req;
    logic [9:0] wiper_code;
    logic [3:0] ctrl_bits;
    logic [4:0] nv_sel;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    int st_cnt = 0, rs_cnt = 0;

    // expected model
    logic [9:0]  m_wiper = '0;
    logic [3:0]  m_ctrl = '0;
    logic        m_sd = 1'b0;
    logic [4:0]  m_sel = '0;
    logic [15:0] m_tx = '0;
    int          m_st = 0, m_rs = 0;

    always #2.5 clk = ~clk;

    spi_wiper_decoder u0 (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
        .store_busy(store_busy), .nv_rdata(nv_rdata), .sdo(sdo),
        .wiper_code(wiper_code), .ctrl_bits(ctrl_bits), .shutdown(shutdown),
        .nv_sel(nv_sel), .store_req(store_req), .restore_req(restore_req)
    );

    always @(posedge clk) begin
        if (store_req)   st_cnt <= st_cnt + 1;
        if (restore_req) rs_cnt <= rs_cnt + 1;
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int cmd, input int data, input logic [1:0] top);
        return {top, 4'(cmd), 10'(data)};
    endfunction

    function automatic logic [15:0] readback(input logic [3:0] cmd);
        case (cmd)
            4'd2:    return {6'd0, m_wiper};
            4'd7:    return {12'd0, m_ctrl};
            4'd5:    return nv_rdata;
            default: return 16'd0;
        endcase
    endfunction

    // busy_mode: 0 none, 1 busy at select fall, 2 busy at select rise
    task automatic send(input string tag, input int n, input logic [63:0] bits, input int busy_mode);
        logic [15:0] w;
        int bad_i;
        logic bad_v;
        bool_valid: begin end
        w = bits[15:0];
        bad_i = -1;
        bad_v = 1'b0;
        @(negedge clk);
        if (busy_mode == 1) store_busy = 1'b1;
        repeat (3) @(negedge clk);
        sync_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            logic e;
            din  = bits[n-1-i];
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            e = (busy_mode == 1) ? 1'b0 : ((i < 16) ? m_tx[15-i] : 1'b0);
            if (sdo !== e && bad_i < 0) begin bad_i = i; bad_v = sdo; end
            sclk = 1'b0;
            repeat (H) @(negedge clk);
        end
        // R2: nothing moves before select rises
        chk({tag, " R2 wiper held mid-frame"}, 32'(wiper_code), 32'(m_wiper));
        chk({tag, " R8 sdo stream first bad bit"}, (bad_i < 0) ? 32'hFFFF : 32'(bad_i) , 32'hFFFF);
        if (bad_i >= 0) $display("  (bit %0d was %0b)", bad_i, bad_v);
        if (busy_mode == 2) begin
            store_busy = 1'b1;
            repeat (4) @(negedge clk);
        end
        sync_n = 1'b1;
        repeat (12) @(negedge clk);
        store_busy = 1'b0;
        // model update
        if (n > 0 && (n % 16) == 0 && busy_mode == 0 && w[15:14] == 2'b00) begin
            m_tx = readback(w[13:10]);
            case (w[13:10])
                4'd1: m_wiper = w[9:0];
                4'd3: m_st++;
                4'd4: m_rs++;
                4'd5: m_sel = w[4:0];
                4'd6: m_ctrl = w[3:0];
                4'd8: m_sd = w[0];
                default: ;
            endcase
        end else begin
            m_tx = 16'd0;
        end
        chk({tag, " R1 wiper_code"}, 32'(wiper_code), 32'(m_wiper));
        chk({tag, " R6 ctrl_bits"}, 32'(ctrl_bits), 32'(m_ctrl));
        chk({tag, " R7 shutdown"}, 32'(shutdown), 32'(m_sd));
        chk({tag, " R8 nv_sel"}, 32'(nv_sel), 32'(m_sel));
        chk({tag, " R10 store strobes"}, 32'(st_cnt), 32'(m_st));
        chk({tag, " R10 restore strobes"}, 32'(rs_cnt), 32'(m_rs));
        chk({tag, " R9 sdo idle"}, 32'(sdo), 32'd0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R13 reset state
        chk("R13 wiper", 32'(wiper_code), 0);
        chk("R13 ctrl", 32'(ctrl_bits), 0);
        chk("R13 shutdown", 32'(shutdown), 0);
        chk("R13 nv_sel", 32'(nv_sel), 0);
        chk("R13 sdo", 32'(sdo), 0);
        chk("R13 strobes", 32'({store_req, restore_req}), 0);

        send("R1_wr",    16, 64'(mk(1, 10'h2AB, 2'b00)), 0);
        send("R8_rdw",   16, 64'(mk(2, 0, 2'b00)), 0);
        send("R8_out",   16, 64'(mk(0, 0, 2'b00)), 0);
        send("R9_zero",  16, 64'(mk(0, 0, 2'b00)), 0);
        send("R6_ctrl",  16, 64'(mk(6, 10'h3FA, 2'b00)), 0);
        send("R8_rdc",   16, 64'(mk(7, 0, 2'b00)), 0);
        send("R8_out32", 32, 64'(mk(0, 0, 2'b00)), 0);
        send("R7_on",    16, 64'(mk(8, 1, 2'b00)), 0);
        send("R7_off",   16, 64'(mk(8, 10'h3FE, 2'b00)), 0);
        send("R3_len31", 31, 64'(mk(1, 10'h155, 2'b00)), 0);
        send("R3_len33", 33, 64'(mk(1, 10'h0F0, 2'b00)), 0);
        send("R3_len0",   0, 64'(mk(1, 10'h0F0, 2'b00)), 0);
        send("R3_len15", 15, 64'(mk(8, 1, 2'b00)), 0);
        send("R4_len32", 32, {32'd0, 16'hFFFF, mk(1, 10'h0C3, 2'b00)}, 0);
        send("R5_top",   16, 64'(mk(1, 10'h3FF, 2'b10)), 0);
        send("R10_st",   16, 64'(mk(3, 0, 2'b00)), 0);
        send("R10_rs",   16, 64'(mk(4, 0, 2'b00)), 0);
        send("R11_nop",  16, 64'(mk(12, 10'h3FF, 2'b00)), 0);
        send("R11_zero", 16, 64'(mk(0, 10'h3FF, 2'b00)), 0);
        send("R12_rdw",  16, 64'(mk(2, 0, 2'b00)), 0);
        send("R12_fall", 16, 64'(mk(1, 10'h011, 2'b00)), 1);
        send("R12_rise", 16, 64'(mk(6, 10'h005, 2'b00)), 2);
        nv_rdata = 16'h1E3C;
        send("R8_rdnv",  16, 64'(mk(5, 10'h013, 2'b00)), 0);
        send("R8_nvout", 16, 64'(mk(0, 0, 2'b00)), 0);
        send("R1_zero",  16, 64'(mk(1, 0, 2'b00)), 0);

        for (int k = 0; k < 110; k++) begin
            int lens[12] = '{16, 16, 16, 16, 32, 48, 15, 17, 31, 33, 0, 8};
            int len, cmd, bm;
            logic [1:0] top;
            logic [63:0] b;
            len = lens[$urandom_range(0, 11)];
            cmd = $urandom_range(0, 15);
            top = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            bm  = ($urandom_range(0, 15) == 0) ? int'($urandom_range(1, 2)) : 0;
            b   = {$urandom(), $urandom()};
            b[15:0] = mk(cmd, $urandom_range(0, 1023), top);
            nv_rdata = 16'($urandom());
            send("rand", len, b, bm);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all) act=timeout exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule